// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block carries 18-bit words between two ports, called A and B, with one independent path for each direction. Each path holds a storage element that works in one of two ways. While its transparency control is high, the element passes the input straight through to the opposite port's output. While that control is low, the element is an edge-triggered register. It loads the input on a rising edge of its capture strobe, and only when its active-low strobe enable is asserted. Otherwise it keeps its content. Each path also has an active-low output enable. That enable produces a drive flag, which the pad ring or an inout wrapper uses to decide whether to drive the port or leave it at high impedance.

The paths are identical and share nothing except the system clock and reset. The capture strobes are ordinary signals sampled on the system clock. A strobe counts as rising when it is seen high on a clock edge after being seen low on the previous edge. A transfer is a plain level interface with no handshake. The receiving side reads the output whenever the drive flag is high, and the sender cannot be stalled.

Top module: `xcvr_bidir`

## Requirements
- R1: While a path's transparency control is high, its output equals its input in the same cycle, bit for bit and not inverted (A input to B output, B input to A output).
- R2: While the transparency control is low and no enabled strobe rise occurs, the output keeps its stored value whatever the input does.
- R3: With transparency low and strobe enable low, a strobe sampled low on one clock edge and high on the next loads the input present at that second edge; the output shows it from that edge on.
- R4: A path's drive flag is high exactly while its active-low output enable is low; the output data keeps its stored value while the flag is low.
- R5: While the strobe enable is high (deasserted), a strobe rise does not change the stored value.
- R6: Transparency overrides the strobe and its enable; after the transparency control falls, the output holds the input sampled on the last clock edge with transparency high, until the next enabled strobe rise.
- R7: The controls and data of one direction never change the output of the other direction.
- R8: Reset clears both stored values to zero, visible on both outputs while transparency is low.
- R9: A strobe held high loads only once, on its rising edge; later edges with the strobe still high do not load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples strobes and updates storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | Data arriving on port A |
| b_in | input | 18 | Data arriving on port B |
| a_out | output | 18 | Data presented to port A (from the B-to-A path) |
| b_out | output | 18 | Data presented to port B (from the A-to-B path) |
| a_drv | output | 1 | High when port A should be driven |
| b_drv | output | 1 | High when port B should be driven |
| ab_le | input | 1 | A-to-B transparency control, active high |
| ab_strb | input | 1 | A-to-B capture strobe |
| ab_cke_n | input | 1 | A-to-B strobe enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_le | input | 1 | B-to-A transparency control, active high |
| ba_strb | input | 1 | B-to-A capture strobe |
| ba_cke_n | input | 1 | B-to-A strobe enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
The hardest case to reach is the handover from transparent to registered mode: the value that stays visible after transparency drops, and its survival through strobe rises that are blocked or that come from a strobe held high. A directed sequence puts a known word through in transparent mode and drops the control. It then changes the input and steps the strobe through a blocked rise, an enabled rise and a held-high level, checking the exact word after each step. A counting sweep over both directions' control bits, with arithmetically derived data, then covers the other mode combinations against a reference model in the bench.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_DIRS = 2;
  localparam int unsigned XCVR_AB   = 0;
  localparam int unsigned XCVR_BA   = 1;

  typedef struct packed {
    logic le;
    logic strb;
    logic cke_n;
    logic oe_n;
  } xcvr_ctl_t;
endpackage

// File: rtl/xcvr_strobe_edge.sv
module xcvr_strobe_edge (
  input  logic clk,
  input  logic strb,
  output logic rise
);
  logic strb_q;

  // Tracks the strobe even during reset so release never fakes an edge.
  always_ff @(posedge clk) begin
    strb_q <= strb;
  end

  assign rise = strb & ~strb_q;
endmodule

// File: rtl/xcvr_store_cell.sv
module xcvr_store_cell #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             le,
  input  logic             cke_n,
  input  logic             rise,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  logic load;

  assign load = le | (~cke_n & rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= din;
    end
  end
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  xcvr_ctl_t        ctl,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             drive
);
  logic             rise;
  logic [WIDTH-1:0] held;

  xcvr_strobe_edge u_edge (
    .clk  (clk),
    .strb (ctl.strb),
    .rise (rise)
  );

  xcvr_store_cell #(.WIDTH(WIDTH)) u_cell (
    .clk   (clk),
    .rst_n (rst_n),
    .le    (ctl.le),
    .cke_n (ctl.cke_n),
    .rise  (rise),
    .din   (din),
    .q     (held)
  );

  assign dout  = ctl.le ? din : held;
  assign drive = ~ctl.oe_n;
endmodule

// File: rtl/xcvr_bidir.sv
module xcvr_bidir
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] b_out,
  output logic             a_drv,
  output logic             b_drv,
  input  logic             ab_le,
  input  logic             ab_strb,
  input  logic             ab_cke_n,
  input  logic             ab_oe_n,
  input  logic             ba_le,
  input  logic             ba_strb,
  input  logic             ba_cke_n,
  input  logic             ba_oe_n
);
  xcvr_ctl_t        ctl  [XCVR_DIRS];
  logic [WIDTH-1:0] din  [XCVR_DIRS];
  logic [WIDTH-1:0] dout [XCVR_DIRS];
  logic             drv  [XCVR_DIRS];

  assign ctl[XCVR_AB] = '{le: ab_le, strb: ab_strb, cke_n: ab_cke_n, oe_n: ab_oe_n};
  assign ctl[XCVR_BA] = '{le: ba_le, strb: ba_strb, cke_n: ba_cke_n, oe_n: ba_oe_n};
  assign din[XCVR_AB] = a_in;
  assign din[XCVR_BA] = b_in;

  for (genvar g = 0; g < XCVR_DIRS; g++) begin : g_dir
    xcvr_path #(.WIDTH(WIDTH)) u_path (
      .clk   (clk),
      .rst_n (rst_n),
      .ctl   (ctl[g]),
      .din   (din[g]),
      .dout  (dout[g]),
      .drive (drv[g])
    );
  end

  assign b_out = dout[XCVR_AB];
  assign b_drv = drv[XCVR_AB];
  assign a_out = dout[XCVR_BA];
  assign a_drv = drv[XCVR_BA];
endmodule

// File: rtl/xcvr_bidir_chk.sv
module xcvr_bidir_chk #(
  parameter int unsigned WIDTH = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] a_out,
  input logic [WIDTH-1:0] b_out,
  input logic             ab_le,
  input logic             ab_strb,
  input logic             ab_cke_n,
  input logic             ba_le,
  input logic             ba_strb,
  input logic             ba_cke_n
);
  // R3
  ab_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && !ab_cke_n && ab_strb && !$past(ab_strb)) ##1 !ab_le |-> b_out == $past(a_in));

  // R5
  ab_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && ab_cke_n) ##1 !ab_le |-> $stable(b_out));

  // R6
  ab_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && $past(ab_le)) |-> b_out == $past(a_in));

  // R9
  ab_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && ab_strb && $past(ab_strb)) ##1 !ab_le |-> $stable(b_out));

  // R7
  ba_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_le && !ba_cke_n && ba_strb && !$past(ba_strb)) ##1 !ba_le |-> a_out == $past(b_in));

  // R7
  ba_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_le && ba_cke_n) ##1 !ba_le |-> $stable(a_out));
endmodule

bind xcvr_bidir xcvr_bidir_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .a_in     (a_in),
  .b_in     (b_in),
  .a_out    (a_out),
  .b_out    (b_out),
  .ab_le    (ab_le),
  .ab_strb  (ab_strb),
  .ab_cke_n (ab_cke_n),
  .ba_le    (ba_le),
  .ba_strb  (ba_strb),
  .ba_cke_n (ba_cke_n)
);

// File: tb/tb_xcvr_bidir.sv
module tb_xcvr_bidir;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_drv, b_drv;
  logic         ab_le, ab_strb, ab_cke_n, ab_oe_n;
  logic         ba_le, ba_strb, ba_cke_n, ba_oe_n;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  xcvr_bidir #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .b_out(b_out), .a_drv(a_drv), .b_drv(b_drv),
    .ab_le(ab_le), .ab_strb(ab_strb), .ab_cke_n(ab_cke_n), .ab_oe_n(ab_oe_n),
    .ba_le(ba_le), .ba_strb(ba_strb), .ba_cke_n(ba_cke_n), .ba_oe_n(ba_oe_n)
  );

  // Reference model built from the requirements.
  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic         p_ab = 1'b0, p_ba = 1'b0;
  string        t_ab = "R8", t_ba = "R8";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ab = '0; m_ba = '0; t_ab = "R8"; t_ba = "R8";
    end else begin
      if (ab_le) begin m_ab = a_in; t_ab = "R6"; end
      else if (ab_strb && !p_ab && !ab_cke_n) begin m_ab = a_in; t_ab = "R3"; end
      else if (ab_strb && !p_ab) t_ab = "R5";
      else if (ab_strb) t_ab = "R9";
      else t_ab = "R2";
      if (ba_le) begin m_ba = b_in; t_ba = "R6"; end
      else if (ba_strb && !p_ba && !ba_cke_n) begin m_ba = b_in; t_ba = "R3"; end
      else if (ba_strb && !p_ba) t_ba = "R5";
      else if (ba_strb) t_ba = "R9";
      else t_ba = "R2";
    end
    p_ab = ab_strb;
    p_ba = ba_strb;
  end

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_checks();
    chk(ab_le ? "R1" : t_ab, b_out, ab_le ? a_in : m_ab);
    chk(ba_le ? "R1" : {"R7/", t_ba}, a_out, ba_le ? b_in : m_ba);
    chk("R4", W'(b_drv), W'(!ab_oe_n));
    chk("R4", W'(a_drv), W'(!ba_oe_n));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a_in = '0; b_in = '0;
    ab_le = 0; ab_strb = 0; ab_cke_n = 0; ab_oe_n = 1;
    ba_le = 0; ba_strb = 0; ba_cke_n = 1; ba_oe_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ab_oe_n = 1'b0;
    a_in = 18'h1BEEF; b_in = 18'h2C0DE;
    #2;
    // R8: cleared values visible with transparency low
    chk("R8", b_out, '0);
    chk("R8", a_out, '0);
    chk("R4", W'(b_drv), W'(1));

    // R1: transparency passes A straight through
    @(negedge clk); ab_le = 1; a_in = 18'h2A5A5; #2;
    chk("R1", b_out, 18'h2A5A5);
    // R6: falling transparency freezes last value
    @(negedge clk); ab_le = 0; a_in = 18'h01234; #2;
    chk("R6", b_out, 18'h2A5A5);
    @(negedge clk); #2;
    chk("R2", b_out, 18'h2A5A5);
    // R3: enabled strobe rise loads at the next edge
    @(negedge clk); ab_strb = 1; #2;
    chk("R3", b_out, 18'h2A5A5);
    @(negedge clk); a_in = 18'h3FFFF; #2;
    chk("R3", b_out, 18'h01234);
    // R9: strobe held high does not reload
    @(negedge clk); #2;
    chk("R9", b_out, 18'h01234);
    // R5: blocked rise keeps the value
    @(negedge clk); ab_strb = 0;
    @(negedge clk); ab_strb = 1; ab_cke_n = 1;
    @(negedge clk); #2;
    chk("R5", b_out, 18'h01234);
    // R7: B-to-A output untouched by all of the above
    chk("R7", a_out, '0);
    // R4: output disabled, data retained
    @(negedge clk); ab_oe_n = 1; #2;
    chk("R4", W'(b_drv), W'(0));
    chk("R4", b_out, 18'h01234);

    // Sweep over both directions' control bits with derived data.
    for (int i = 0; i < 4096; i++) begin
      @(negedge clk);
      begin
        logic [11:0] c;
        c = 12'(i) ^ 12'(i >> 5);
        ab_le    = c[0] & c[3];
        ab_strb  = c[1];
        ab_cke_n = c[2] & c[5];
        ab_oe_n  = c[4];
        ba_le    = c[6] & c[9];
        ba_strb  = c[7];
        ba_cke_n = c[8] & c[11];
        ba_oe_n  = c[10];
        a_in     = W'(i * 40503 + 7);
        b_in     = W'((i * 2654435) ^ (i << 9));
      end
      #2;
      model_checks();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule